// File: doc/BRIEF.md
# Direct-Mapped Translation Buffer with Dirty Tracking

This block caches four virtual-to-physical page translations for a 38-bit virtual space and a 26-bit physical space with 256-byte pages. A request presents a virtual address and says whether it is a load or a store. In the same cycle the block answers with hit or miss and, on a hit, the physical address. Each virtual page number has one possible slot, chosen by its two lowest bits. The rest of the page number is kept as a tag.

Every slot holds a valid flag, a dirty flag and a physical page number. The dirty flag must always equal the page-table copy. So when a store hits a clean slot, the block pulses a dirty-update request for that cycle, and the slot becomes dirty at the next clock edge. The page-table walker reloads a slot through the refill port after a miss. The fault handler drops a stale mapping through the invalidate port, which names a virtual page.

Top module: `tlb_direct_map`

## Requirements
- R1: After reset every slot is invalid, so every lookup, load or store, misses and raises no dirty-update request.
- R2: A lookup hits only when the lookup strobe is high, the slot picked by virtual address bits 9:8 is valid, and the stored tag equals virtual address bits 37:10. Otherwise it misses.
- R3: On a hit the physical address is the slot's 18-bit page number in bits 25:8 and virtual address bits 7:0 in bits 7:0. On a miss the physical address is zero.
- R4: A store that hits a clean slot raises the dirty-update request in that cycle and makes the slot dirty from the next cycle on. A later store to that page raises no request. A load hit never changes the dirty flag.
- R5: A refill writes the valid flag, dirty flag, tag and page number given on the refill port into the slot picked by refill page-number bits 1:0, whatever the slot held before. A lookup in the same cycle still sees the old contents; the next cycle sees the new ones.
- R6: An invalidate clears the valid flag of the slot picked by its page-number bits 1:0 only when the stored tag equals page-number bits 29:2. With any other tag the slot keeps mapping its page.
- R7: Two pages with equal low page-number bits evict each other. Pages with different low bits are held side by side.
- R8: When several updates reach one slot in the same cycle, refill wins over invalidate, and invalidate wins over the dirty-set from a store hit.
- R9: A store that misses, or that hits a slot that is already dirty, raises no dirty-update request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup strobe |
| lk_va | input | 38 | Lookup virtual address |
| lk_store | input | 1 | Lookup is a store |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 26 | Translated physical address, zero on a miss |
| lk_dirty_req | output | 1 | Store hit a clean slot; page-table dirty flag must be set |
| fill_valid | input | 1 | Refill strobe |
| fill_vpn | input | 30 | Page number being refilled |
| fill_v | input | 1 | Valid flag to write |
| fill_d | input | 1 | Dirty flag to write |
| fill_ppn | input | 18 | Physical page number to write |
| inv_valid | input | 1 | Invalidate strobe |
| inv_vpn | input | 30 | Page number to invalidate |

## Verification
The bench sweeps every slot and several offsets, then runs a long mixed stream over a small tag set so that collisions are frequent. Each result is compared against a model written from the requirements.

The bench targets these corner cases:
- **Same-cycle refill.** A lookup in the same cycle as a refill must return the old result. A design that forwards the refill would return a hit one cycle early.
- **Invalidate with a wrong tag.** An invalidate whose tag does not match must leave the slot in place. A design that ignores the tag would lose a live mapping and miss afterwards.
- **Repeated stores.** A second store to the same page must not raise the request again. A design that never records the dirty flag would keep asking the page table to update.
- **Colliding updates.** When refill, invalidate and a store's dirty-set hit one slot together, the refill must win. A design with the wrong priority would keep the old tag or leave the new page dirty, and later lookups would expose it.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int unsigned TLB_VA_W    = 38;
  localparam int unsigned TLB_PA_W    = 26;
  localparam int unsigned TLB_OFF_W   = 8;
  localparam int unsigned TLB_ENTRIES = 4;

  // Which change a slot takes at the next edge, highest priority first.
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_FILL  = 2'd1,
    UPD_INVAL = 2'd2,
    UPD_MARK  = 2'd3
  } tlb_upd_e;
endpackage

// File: rtl/tlb_rst_sync.sv
`timescale 1ns/1ps
module tlb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tlb_va_split.sv
`timescale 1ns/1ps
module tlb_va_split #(
  parameter int unsigned VA_W  = 38,
  parameter int unsigned OFF_W = 8,
  parameter int unsigned IDX_W = 2,
  localparam int unsigned TAG_W = VA_W - OFF_W - IDX_W
) (
  input  logic [VA_W-1:0]  va,
  output logic [OFF_W-1:0] off,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  assign off = va[OFF_W-1:0];
  assign idx = va[OFF_W+IDX_W-1:OFF_W];
  assign tag = va[VA_W-1:OFF_W+IDX_W];
endmodule

// File: rtl/tlb_entry.sv
`timescale 1ns/1ps
module tlb_entry
  import tlb_pkg::*;
#(
  parameter int unsigned TAG_W = 28,
  parameter int unsigned PPN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_we,
  input  logic             fill_v,
  input  logic             fill_d,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inv_req,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             mark_dirty,
  output logic             valid_q,
  output logic             dirty_q,
  output logic [TAG_W-1:0] tag_q,
  output logic [PPN_W-1:0] ppn_q
);
  tlb_upd_e         upd;
  logic             valid_d;
  logic             dirty_d;
  logic             flag_en;
  logic             load_en;

  // Next-state selection: refill > invalidate (tag match) > dirty mark.
  always_comb begin
    if (fill_we)                         upd = UPD_FILL;
    else if (inv_req && inv_tag == tag_q) upd = UPD_INVAL;
    else if (mark_dirty)                 upd = UPD_MARK;
    else                                 upd = UPD_NONE;
  end

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    flag_en = 1'b0;
    load_en = 1'b0;
    case (upd)
      UPD_FILL: begin
        valid_d = fill_v;
        dirty_d = fill_d;
        flag_en = 1'b1;
        load_en = 1'b1;
      end
      UPD_INVAL: begin
        valid_d = 1'b0;
        flag_en = 1'b1;
      end
      UPD_MARK: begin
        dirty_d = 1'b1;
        flag_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dirty_q <= 1'b0;
    end else if (flag_en) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  // Payload carries no reset; it is only meaningful while valid_q is set.
  always_ff @(posedge clk) begin
    if (load_en) begin
      tag_q <= fill_tag;
      ppn_q <= fill_ppn;
    end
  end

  assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> (valid_q == $past(fill_v) && dirty_q == $past(fill_d)
                 && tag_q == $past(fill_tag) && ppn_q == $past(fill_ppn)));

  assert_inv_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && inv_tag == tag_q && !fill_we) |=> !valid_q);

  assert_inv_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && inv_tag != tag_q && !fill_we) |=> valid_q == $past(valid_q));

  assert_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_dirty && !fill_we && !(inv_req && inv_tag == tag_q)) |=> dirty_q);

  assert_dirty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dirty_q) |-> $past(fill_we));
endmodule

// File: rtl/tlb_lookup.sv
`timescale 1ns/1ps
module tlb_lookup #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned TAG_W   = 28,
  parameter int unsigned PPN_W   = 18,
  parameter int unsigned OFF_W   = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned PA_W   = PPN_W + OFF_W
) (
  input  logic                          req_valid,
  input  logic                          req_store,
  input  logic [IDX_W-1:0]              req_idx,
  input  logic [TAG_W-1:0]              req_tag,
  input  logic [OFF_W-1:0]              req_off,
  input  logic [ENTRIES-1:0]            ent_valid,
  input  logic [ENTRIES-1:0]            ent_dirty,
  input  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
  input  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn,
  output logic                          hit,
  output logic [PA_W-1:0]               pa,
  output logic                          dirty_req,
  output logic [ENTRIES-1:0]            mark_vec
);
  logic [ENTRIES-1:0] sel;
  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
    assign sel[i]   = (req_idx == SLOT);
    assign match[i] = sel[i] && ent_valid[i] && (ent_tag[i] == req_tag);
  end

  logic [PPN_W-1:0] ppn_sel;
  logic             dirty_sel;

  always_comb begin
    ppn_sel   = '0;
    dirty_sel = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        ppn_sel   = ent_ppn[i];
        dirty_sel = ent_dirty[i];
      end
    end
  end

  always_comb begin
    hit       = req_valid && (|match);
    pa        = hit ? {ppn_sel, req_off} : '0;
    dirty_req = hit && req_store && !dirty_sel;
    mark_vec  = dirty_req ? sel : '0;
  end
endmodule

// File: rtl/tlb_direct_map.sv
`timescale 1ns/1ps
module tlb_direct_map
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W    = TLB_VA_W,
  parameter int unsigned PA_W    = TLB_PA_W,
  parameter int unsigned OFF_W   = TLB_OFF_W,
  parameter int unsigned ENTRIES = TLB_ENTRIES,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned TAG_W  = VPN_W - IDX_W,
  localparam int unsigned PPN_W  = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             lk_store,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_pa,
  output logic             lk_dirty_req,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_v,
  input  logic             fill_d,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn
);
  logic rst_n_sync;

  tlb_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  logic [OFF_W-1:0] lk_off;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;

  tlb_va_split #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_split (
    .va  (lk_va),
    .off (lk_off),
    .idx (lk_idx),
    .tag (lk_tag)
  );

  logic [IDX_W-1:0] fill_idx;
  logic [TAG_W-1:0] fill_tag;
  logic [IDX_W-1:0] inv_idx;
  logic [TAG_W-1:0] inv_tag;

  assign fill_idx = fill_vpn[IDX_W-1:0];
  assign fill_tag = fill_vpn[VPN_W-1:IDX_W];
  assign inv_idx  = inv_vpn[IDX_W-1:0];
  assign inv_tag  = inv_vpn[VPN_W-1:IDX_W];

  logic [ENTRIES-1:0]            ent_valid;
  logic [ENTRIES-1:0]            ent_dirty;
  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
  logic [ENTRIES-1:0]            mark_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
    logic fill_we;
    logic inv_req;
    assign fill_we = fill_valid && (fill_idx == SLOT);
    assign inv_req = inv_valid && (inv_idx == SLOT);

    tlb_entry #(.TAG_W(TAG_W), .PPN_W(PPN_W)) i_entry (
      .clk        (clk),
      .rst_n      (rst_n_sync),
      .fill_we    (fill_we),
      .fill_v     (fill_v),
      .fill_d     (fill_d),
      .fill_tag   (fill_tag),
      .fill_ppn   (fill_ppn),
      .inv_req    (inv_req),
      .inv_tag    (inv_tag),
      .mark_dirty (mark_vec[i]),
      .valid_q    (ent_valid[i]),
      .dirty_q    (ent_dirty[i]),
      .tag_q      (ent_tag[i]),
      .ppn_q      (ent_ppn[i])
    );
  end

  tlb_lookup #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .PPN_W   (PPN_W),
    .OFF_W   (OFF_W)
  ) i_lookup (
    .req_valid (lk_valid),
    .req_store (lk_store),
    .req_idx   (lk_idx),
    .req_tag   (lk_tag),
    .req_off   (lk_off),
    .ent_valid (ent_valid),
    .ent_dirty (ent_dirty),
    .ent_tag   (ent_tag),
    .ent_ppn   (ent_ppn),
    .hit       (lk_hit),
    .pa        (lk_pa),
    .dirty_req (lk_dirty_req),
    .mark_vec  (mark_vec)
  );

  assert_dreq_store_hit_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    lk_dirty_req |-> (lk_hit && lk_store));

  assert_hit_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    lk_hit |-> lk_valid);

  assert_pa_offset_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    lk_hit |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]));

  assert_dreq_clean_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    lk_dirty_req |=> !(lk_valid && lk_store && $stable(lk_va) && lk_dirty_req));
endmodule

// File: tb/test_tlb_direct_map.sv
`timescale 1ns/1ps
module test_tlb_direct_map;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_store;
  logic [37:0] lk_va;
  logic        lk_hit;
  logic [25:0] lk_pa;
  logic        lk_dirty_req;
  logic        fill_valid, fill_v, fill_d;
  logic [29:0] fill_vpn;
  logic [17:0] fill_ppn;
  logic        inv_valid;
  logic [29:0] inv_vpn;

  int n_cmp = 0;
  int n_bad = 0;

  logic        mv [4];
  logic        md [4];
  logic [27:0] mt [4];
  logic [17:0] mp [4];

  always #5 clk = ~clk;

  tlb_direct_map i_tlb_direct_map (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_store(lk_store),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_dirty_req(lk_dirty_req),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_v(fill_v),
    .fill_d(fill_d), .fill_ppn(fill_ppn),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn)
  );

  function automatic logic [37:0] mkva(input logic [27:0] t, input logic [1:0] i, input logic [7:0] o);
    return {t, i, o};
  endfunction

  function automatic logic [29:0] mkvpn(input logic [27:0] t, input logic [1:0] i);
    return {t, i};
  endfunction

  task automatic check(input string req, input logic h, input logic eh,
                       input logic [25:0] p, input logic [25:0] ep,
                       input logic d, input logic ed);
    n_cmp++;
    if (h !== eh || p !== ep || d !== ed) begin
      n_bad++;
      $display("FAIL %s: hit/pa/dreq got %0b/%h/%0b expected %0b/%h/%0b",
               req, h, p, d, eh, ep, ed);
    end
  endtask

  // One cycle with any mix of lookup, refill and invalidate.
  task automatic step(input logic lv, input logic [37:0] va, input logic st,
                      input logic fv, input logic [29:0] fvpn, input logic fval,
                      input logic fdir, input logic [17:0] fppn,
                      input logic iv, input logic [29:0] ivpn, input string req);
    logic [1:0]  li;
    logic [27:0] lt;
    logic        eh, ed;
    logic [25:0] ep;
    @(negedge clk);
    lk_valid = lv; lk_va = va; lk_store = st;
    fill_valid = fv; fill_vpn = fvpn; fill_v = fval; fill_d = fdir; fill_ppn = fppn;
    inv_valid = iv; inv_vpn = ivpn;
    #1;
    li = va[9:8];
    lt = va[37:10];
    eh = lv && mv[li] && (mt[li] == lt);
    ep = eh ? {mp[li], va[7:0]} : 26'd0;
    ed = eh && st && !md[li];
    check(req, lk_hit, eh, lk_pa, ep, lk_dirty_req, ed);
    @(posedge clk);
    for (int e = 0; e < 4; e++) begin
      if (fv && fvpn[1:0] == 2'(e)) begin
        mv[e] = fval; md[e] = fdir; mt[e] = fvpn[29:2]; mp[e] = fppn;
      end else if (iv && ivpn[1:0] == 2'(e) && mt[e] == ivpn[29:2]) begin
        mv[e] = 1'b0;
      end else if (ed && li == 2'(e)) begin
        md[e] = 1'b1;
      end
    end
    #1;
    lk_valid = 1'b0; lk_store = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0;
  endtask

  task automatic look(input logic [37:0] va, input logic st, input string req);
    step(1'b1, va, st, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, '0, req);
  endtask

  task automatic fill(input logic [29:0] vpn, input logic v, input logic d,
                      input logic [17:0] ppn, input string req);
    step(1'b0, '0, 1'b0, 1'b1, vpn, v, d, ppn, 1'b0, '0, req);
  endtask

  task automatic inval(input logic [29:0] vpn, input string req);
    step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b1, vpn, req);
  endtask

  function automatic logic [27:0] tag_of(input int i);
    return 28'(i * 3 + 5);
  endfunction

  function automatic logic [17:0] ppn_of(input int i);
    return 18'h2A000 ^ 18'(i * 18'h1111);
  endfunction

  logic [31:0] rs;

  initial begin
    for (int e = 0; e < 4; e++) begin
      mv[e] = 1'b0; md[e] = 1'b0; mt[e] = '0; mp[e] = '0;
    end
    rst_n = 1'b0;
    lk_valid = 0; lk_store = 0; lk_va = '0;
    fill_valid = 0; fill_vpn = '0; fill_v = 0; fill_d = 0; fill_ppn = '0;
    inv_valid = 0; inv_vpn = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: empty after reset
    for (int i = 0; i < 4; i++) begin
      look(mkva(28'd0, 2'(i), 8'h00), 1'b1, "R1");
      look(mkva(tag_of(i), 2'(i), 8'h7F), 1'b0, "R1");
    end

    // R5: fill every slot, odd slots dirty
    for (int i = 0; i < 4; i++)
      fill(mkvpn(tag_of(i), 2'(i)), 1'b1, 1'(i % 2), ppn_of(i), "R5");

    // R2/R3: offsets, wrong tag, strobe low
    for (int i = 0; i < 4; i++) begin
      look(mkva(tag_of(i), 2'(i), 8'h00), 1'b0, "R3");
      look(mkva(tag_of(i), 2'(i), 8'h5A), 1'b0, "R3");
      look(mkva(tag_of(i), 2'(i), 8'hFF), 1'b0, "R3");
      look(mkva(tag_of(i) ^ 28'h1, 2'(i), 8'h10), 1'b0, "R2");
      look(mkva(tag_of(i), 2'(i ^ 1), 8'h10), 1'b0, "R2");
      step(1'b0, mkva(tag_of(i), 2'(i), 8'h20), 1'b1, 1'b0, '0, 1'b0, 1'b0, '0,
           1'b0, '0, "R2");
    end

    // R4/R9: store on clean then again; load does not mark
    look(mkva(tag_of(2), 2'd2, 8'h01), 1'b0, "R4");
    look(mkva(tag_of(2), 2'd2, 8'h01), 1'b1, "R4");
    for (int i = 0; i < 4; i++) begin
      look(mkva(tag_of(i), 2'(i), 8'h33), 1'b1, "R4");
      look(mkva(tag_of(i), 2'(i), 8'h34), 1'b1, "R9");
    end
    look(mkva(28'h0ABCDEF, 2'd1, 8'h00), 1'b1, "R9");

    // R7: eviction in slot 2, others kept
    fill(mkvpn(28'd77, 2'd2), 1'b1, 1'b0, 18'h00F0F, "R7");
    look(mkva(tag_of(2), 2'd2, 8'h00), 1'b0, "R7");
    look(mkva(28'd77, 2'd2, 8'h44), 1'b0, "R7");
    look(mkva(tag_of(1), 2'd1, 8'h44), 1'b0, "R7");

    // R6: wrong-tag invalidate keeps, matching one clears
    inval(mkvpn(28'd999, 2'd3), "R6");
    look(mkva(tag_of(3), 2'd3, 8'h12), 1'b0, "R6");
    inval(mkvpn(tag_of(3), 2'd3), "R6");
    look(mkva(tag_of(3), 2'd3, 8'h12), 1'b0, "R6");

    // R5: refill not visible in its own cycle; refill of invalid entry
    step(1'b1, mkva(28'd40, 2'd3, 8'h09), 1'b0, 1'b1, mkvpn(28'd40, 2'd3), 1'b1, 1'b0,
         18'h3FFFF, 1'b0, '0, "R5");
    look(mkva(28'd40, 2'd3, 8'h09), 1'b0, "R5");
    fill(mkvpn(tag_of(1), 2'd1), 1'b0, 1'b0, 18'h11111, "R5");
    look(mkva(tag_of(1), 2'd1, 8'h00), 1'b0, "R5");

    // R8: refill beats invalidate; refill beats dirty mark
    step(1'b0, '0, 1'b0, 1'b1, mkvpn(28'd50, 2'd0), 1'b1, 1'b0, 18'h01234,
         1'b1, mkvpn(tag_of(0), 2'd0), "R8");
    step(1'b0, '0, 1'b0, 1'b1, mkvpn(28'd51, 2'd0), 1'b1, 1'b0, 18'h05678,
         1'b1, mkvpn(28'd51, 2'd0), "R8");
    look(mkva(28'd51, 2'd0, 8'h77), 1'b0, "R8");
    step(1'b1, mkva(28'd51, 2'd0, 8'h01), 1'b1, 1'b1, mkvpn(28'd52, 2'd0), 1'b1, 1'b0,
         18'h09ABC, 1'b0, '0, "R8");
    look(mkva(28'd52, 2'd0, 8'h02), 1'b1, "R8");
    // invalidate beats dirty mark
    fill(mkvpn(28'd60, 2'd1), 1'b1, 1'b0, 18'h00555, "R8");
    step(1'b1, mkva(28'd60, 2'd1, 8'h03), 1'b1, 1'b0, '0, 1'b0, 1'b0, '0,
         1'b1, mkvpn(28'd60, 2'd1), "R8");
    look(mkva(28'd60, 2'd1, 8'h03), 1'b1, "R8");

    // Mixed stream over a small tag set (R2..R9)
    rs = 32'h1D872B41;
    for (int n = 0; n < 600; n++) begin
      logic [27:0] t;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      t = 28'(rs[3:2] % 3);
      case (rs[1:0])
        2'd0: look(mkva(t, rs[5:4], rs[13:6]), rs[14], "R4");
        2'd1: fill(mkvpn(t, rs[5:4]), rs[15] | rs[20], rs[16], rs[31:14], "R5");
        2'd2: inval(mkvpn(t, rs[5:4]), "R6");
        default: step(1'b1, mkva(t, rs[5:4], rs[13:6]), rs[14], rs[17],
                      mkvpn(28'(rs[19:18] % 3), rs[21:20]), 1'b1, rs[22], rs[31:14],
                      rs[23], mkvpn(28'(rs[25:24] % 3), rs[27:26]), "R8");
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule